// File: doc/BRIEF.md
# Cache Line Retirement Engine

This block sits beside a large cache protected by single-error-correct, double-error-detect coding and sorts corrected errors into two kinds: transient upsets, which the error code alone absorbs, and lines with a latent permanent defect. Each error event reported by the cache read path enters a small queue. The engine takes one queued event at a time. For a corrected error on a line still in service, it issues a second read of that same line. If that second read is clean, the event counts as a soft error and the line stays in use. If the second read again needs correction, the engine asks for the line's contents to be moved elsewhere. Once the move is reported done, it sets the line's bit in a disable map, and that bit stays set until reset.

Uncorrectable errors never start a retirement. They are reported on a fatal output. Any event that names a line already disabled is reported as blocked and issues no read. Event input, re-read request and relocate request are valid/ready streams. A source holds its valid and payload until ready is seen high at a clock edge. The engine holds `rd_req_valid`/`rd_req_line` and `mv_req_valid`/`mv_req_line` steady until the matching ready. `evt_ready` falls only when the queue is full. A valid event offered in that state is not taken, and it sets a sticky overflow flag. The re-read response and the relocate-done signal are single-cycle pulses that the engine always accepts.

Top module: `line_retire_engine`

## Requirements
- R1: `evt_ready` is high exactly when the event queue (depth `QDEPTH`) is not full. An accepted event with `evt_corr` or `evt_uncorr` set is queued. An accepted event with neither flag set is dropped with no output activity.
- R2: `ovf` goes high the cycle after `evt_valid` is seen while `evt_ready` is low, and stays high until reset.
- R3: A queued corrected event for an enabled line raises `rd_req_valid` with `rd_req_line` equal to that line. Both hold steady until `rd_req_ready` is seen high.
- R4: If the re-read response is clean (`rd_rsp_valid` with both flags low), no relocate request follows and the line's disable bit stays 0.
- R5: If the re-read response has `rd_rsp_corr` high and `rd_rsp_uncorr` low, `mv_req_valid` rises with `mv_req_line` equal to the line and holds until `mv_req_ready`. The line's bit in `line_dis` (bit index = line number) is still 0 until `mv_done` is seen, and it is 1 from the next cycle on.
- R6: A set `line_dis` bit is cleared only by reset. After reset all bits are 0.
- R7: A queued event with `evt_uncorr` high for an enabled line produces a one-cycle `fatal_valid` pulse with `fatal_line` equal to that line, and no re-read.
- R8: A re-read response with `rd_rsp_uncorr` high produces a one-cycle `fatal_valid` pulse for the line. No relocation follows, and the line stays enabled.
- R9: A queued event for a line whose `line_dis` bit is set produces a one-cycle `blocked_valid` pulse with `blocked_line` equal to that line. This takes priority over `evt_uncorr`, so there is no fatal pulse and no re-read.
- R10: Events are handled one at a time, in arrival order. The next queued event is taken only after the current retirement or re-read has finished.
- R11: In reset, all valid outputs and `ovf` are low and `evt_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Error event offered |
| evt_ready | output | 1 | Event queue can accept |
| evt_line | input | IDX_W | Line index of the event |
| evt_corr | input | 1 | Corrected single-bit error |
| evt_uncorr | input | 1 | Uncorrectable error |
| rd_req_valid | output | 1 | Re-read request valid |
| rd_req_ready | input | 1 | Re-read request accepted |
| rd_req_line | output | IDX_W | Line to re-read |
| rd_rsp_valid | input | 1 | Re-read result pulse |
| rd_rsp_corr | input | 1 | Re-read needed correction |
| rd_rsp_uncorr | input | 1 | Re-read was uncorrectable |
| mv_req_valid | output | 1 | Relocate request valid |
| mv_req_ready | input | 1 | Relocate request accepted |
| mv_req_line | output | IDX_W | Line to relocate |
| mv_done | input | 1 | Relocation complete pulse |
| line_dis | output | LINES | Per-line disable map |
| fatal_valid | output | 1 | Uncorrectable error report pulse |
| fatal_line | output | IDX_W | Line of the uncorrectable error |
| blocked_valid | output | 1 | Access to disabled line pulse |
| blocked_line | output | IDX_W | Line of the blocked access |
| ovf | output | 1 | Sticky queue overflow flag |

## Verification
Call the clock edge that accepts an event E. The queue registers the event at E, and the sequencer takes it at the next edge. So `rd_req_valid`, `fatal_valid` or `blocked_valid` is due in the cycle after E+1, and a pulse lasts only that one cycle. A re-read response seen at an edge moves the engine on by that same edge, so `mv_req_valid` is high in the following cycle. A `mv_done` seen at an edge sets the disable bit for the next cycle. When the queue holds further events, the next re-read request appears two cycles after a clean response. The bench drives inputs and samples outputs on the falling clock edge. Each scenario steps a fixed number of cycles to the cycle where a result is due, and checks both that cycle and the cycle before or after where the result must not yet be present or must have ended.

// File: rtl/lre_pkg.sv
package lre_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_MV_REQ,
    ST_MV_WAIT
  } lre_state_e;
endpackage

// File: rtl/lre_evt_fifo.sv
module lre_evt_fifo #(
  parameter int W     = 7,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] CMAX = CW'(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full      = (cnt_q == CMAX);
  assign out_valid = (cnt_q != '0);
  assign out_data  = mem_q[rd_q];
  assign do_push   = push && !full;
  assign do_pop    = pop && out_valid;

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CMAX);
  // R1
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full);
endmodule

// File: rtl/lre_dis_map.sv
module lre_dis_map #(
  parameter int LINES = 64,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  output logic [LINES-1:0] map
);
  for (genvar g = 0; g < LINES; g++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        bit_q <= 1'b0;
      else if (set_en && (set_idx == IDX_W'(g)))
        bit_q <= 1'b1;
    end
    assign map[g] = bit_q;

    // R6
    dis_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bit_q |=> bit_q);
  end
endmodule

// File: rtl/lre_ctrl.sv
module lre_ctrl
  import lre_pkg::*;
#(
  parameter int LINES = 64,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             head_valid,
  input  logic [IDX_W-1:0] head_line,
  input  logic             head_uncorr,
  output logic             pop,
  input  logic [LINES-1:0] dis_map,
  output logic             rd_req_valid,
  input  logic             rd_req_ready,
  output logic [IDX_W-1:0] rd_req_line,
  input  logic             rd_rsp_valid,
  input  logic             rd_rsp_corr,
  input  logic             rd_rsp_uncorr,
  output logic             mv_req_valid,
  input  logic             mv_req_ready,
  output logic [IDX_W-1:0] mv_req_line,
  input  logic             mv_done,
  output logic             set_en,
  output logic [IDX_W-1:0] set_idx,
  output logic             fatal_valid,
  output logic [IDX_W-1:0] fatal_line,
  output logic             blocked_valid,
  output logic [IDX_W-1:0] blocked_line
);
  lre_state_e       st_q;
  logic [IDX_W-1:0] cur_q;

  assign pop          = (st_q == ST_IDLE) && head_valid;
  assign rd_req_valid = (st_q == ST_RD_REQ);
  assign rd_req_line  = cur_q;
  assign mv_req_valid = (st_q == ST_MV_REQ);
  assign mv_req_line  = cur_q;
  assign set_en       = (st_q == ST_MV_WAIT) && mv_done;
  assign set_idx      = cur_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q          <= ST_IDLE;
      cur_q         <= '0;
      fatal_valid   <= 1'b0;
      fatal_line    <= '0;
      blocked_valid <= 1'b0;
      blocked_line  <= '0;
    end else begin
      fatal_valid   <= 1'b0;
      blocked_valid <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (head_valid) begin
            if (dis_map[head_line]) begin
              blocked_valid <= 1'b1;
              blocked_line  <= head_line;
            end else if (head_uncorr) begin
              fatal_valid <= 1'b1;
              fatal_line  <= head_line;
            end else begin
              cur_q <= head_line;
              st_q  <= ST_RD_REQ;
            end
          end
        end
        ST_RD_REQ:  if (rd_req_ready) st_q <= ST_RD_WAIT;
        ST_RD_WAIT: begin
          if (rd_rsp_valid) begin
            if (rd_rsp_uncorr) begin
              fatal_valid <= 1'b1;
              fatal_line  <= cur_q;
              st_q        <= ST_IDLE;
            end else if (rd_rsp_corr) begin
              st_q <= ST_MV_REQ;
            end else begin
              st_q <= ST_IDLE;
            end
          end
        end
        ST_MV_REQ:  if (mv_req_ready) st_q <= ST_MV_WAIT;
        ST_MV_WAIT: if (mv_done) st_q <= ST_IDLE;
        default:    st_q <= ST_IDLE;
      endcase
    end
  end

  // R3
  rd_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_line)));
  // R5
  mv_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_req_valid && !mv_req_ready) |=> (mv_req_valid && $stable(mv_req_line)));
  // R9
  report_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fatal_valid, blocked_valid}));
  // R10
  one_at_a_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid || mv_req_valid) |-> !pop);
  // R8
  no_move_after_fatal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_valid |-> !mv_req_valid);
endmodule

// File: rtl/line_retire_engine.sv
module line_retire_engine #(
  parameter int LINES  = 64,
  parameter int QDEPTH = 4,
  parameter int IDX_W  = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_valid,
  output logic             evt_ready,
  input  logic [IDX_W-1:0] evt_line,
  input  logic             evt_corr,
  input  logic             evt_uncorr,
  output logic             rd_req_valid,
  input  logic             rd_req_ready,
  output logic [IDX_W-1:0] rd_req_line,
  input  logic             rd_rsp_valid,
  input  logic             rd_rsp_corr,
  input  logic             rd_rsp_uncorr,
  output logic             mv_req_valid,
  input  logic             mv_req_ready,
  output logic [IDX_W-1:0] mv_req_line,
  input  logic             mv_done,
  output logic [LINES-1:0] line_dis,
  output logic             fatal_valid,
  output logic [IDX_W-1:0] fatal_line,
  output logic             blocked_valid,
  output logic [IDX_W-1:0] blocked_line,
  output logic             ovf
);
  localparam int EW = IDX_W + 1;

  logic          q_full, q_push, q_pop, q_valid;
  logic [EW-1:0] q_out;
  logic          set_en;
  logic [IDX_W-1:0] set_idx;

  assign evt_ready = !q_full;
  assign q_push    = evt_valid && evt_ready && (evt_corr || evt_uncorr);

  always_ff @(posedge clk) begin
    if (!rst_n)
      ovf <= 1'b0;
    else if (evt_valid && !evt_ready)
      ovf <= 1'b1;
  end

  // R2
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);

  lre_evt_fifo #(.W(EW), .DEPTH(QDEPTH)) i_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (q_push),
    .push_data ({evt_uncorr, evt_line}),
    .pop       (q_pop),
    .out_valid (q_valid),
    .out_data  (q_out),
    .full      (q_full)
  );

  lre_ctrl #(.LINES(LINES), .IDX_W(IDX_W)) i_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .head_valid    (q_valid),
    .head_line     (q_out[IDX_W-1:0]),
    .head_uncorr   (q_out[EW-1]),
    .pop           (q_pop),
    .dis_map       (line_dis),
    .rd_req_valid  (rd_req_valid),
    .rd_req_ready  (rd_req_ready),
    .rd_req_line   (rd_req_line),
    .rd_rsp_valid  (rd_rsp_valid),
    .rd_rsp_corr   (rd_rsp_corr),
    .rd_rsp_uncorr (rd_rsp_uncorr),
    .mv_req_valid  (mv_req_valid),
    .mv_req_ready  (mv_req_ready),
    .mv_req_line   (mv_req_line),
    .mv_done       (mv_done),
    .set_en        (set_en),
    .set_idx       (set_idx),
    .fatal_valid   (fatal_valid),
    .fatal_line    (fatal_line),
    .blocked_valid (blocked_valid),
    .blocked_line  (blocked_line)
  );

  lre_dis_map #(.LINES(LINES), .IDX_W(IDX_W)) i_map (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (set_en),
    .set_idx (set_idx),
    .map     (line_dis)
  );
endmodule

// File: tb/test_line_retire_engine.sv
module test_line_retire_engine;
  localparam int LINES  = 64;
  localparam int QDEPTH = 4;
  localparam int IDX_W  = $clog2(LINES);

  logic clk = 1'b0;
  logic rst_n;
  logic evt_valid, evt_ready, evt_corr, evt_uncorr;
  logic [IDX_W-1:0] evt_line;
  logic rd_req_valid, rd_req_ready;
  logic [IDX_W-1:0] rd_req_line;
  logic rd_rsp_valid, rd_rsp_corr, rd_rsp_uncorr;
  logic mv_req_valid, mv_req_ready;
  logic [IDX_W-1:0] mv_req_line;
  logic mv_done;
  logic [LINES-1:0] line_dis;
  logic fatal_valid, blocked_valid, ovf;
  logic [IDX_W-1:0] fatal_line, blocked_line;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  line_retire_engine #(.LINES(LINES), .QDEPTH(QDEPTH)) i_line_retire_engine (
    .clk(clk), .rst_n(rst_n),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_line(evt_line),
    .evt_corr(evt_corr), .evt_uncorr(evt_uncorr),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_line(rd_req_line),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_corr(rd_rsp_corr), .rd_rsp_uncorr(rd_rsp_uncorr),
    .mv_req_valid(mv_req_valid), .mv_req_ready(mv_req_ready), .mv_req_line(mv_req_line),
    .mv_done(mv_done), .line_dis(line_dis),
    .fatal_valid(fatal_valid), .fatal_line(fatal_line),
    .blocked_valid(blocked_valid), .blocked_line(blocked_line), .ovf(ovf)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push(input int line, input bit c, input bit u);
    evt_valid  = 1'b1;
    evt_line   = IDX_W'(line);
    evt_corr   = c;
    evt_uncorr = u;
    step();
    evt_valid  = 1'b0;
    evt_corr   = 1'b0;
    evt_uncorr = 1'b0;
  endtask

  task automatic respond(input bit c, input bit u);
    rd_rsp_valid  = 1'b1;
    rd_rsp_corr   = c;
    rd_rsp_uncorr = u;
    step();
    rd_rsp_valid  = 1'b0;
    rd_rsp_corr   = 1'b0;
    rd_rsp_uncorr = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step();
    step();
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    chk(line_dis == '0, "R11 line_dis after reset", longint'(line_dis), 0);
    chk(evt_ready == 1'b1, "R11 evt_ready after reset", evt_ready, 1);
    chk(ovf == 1'b0, "R11 ovf after reset", ovf, 0);
    chk({rd_req_valid, mv_req_valid, fatal_valid, blocked_valid} == 4'b0,
        "R11 valids after reset", {rd_req_valid, mv_req_valid, fatal_valid, blocked_valid}, 0);
  endtask

  task automatic t_clean_evt();
    push(3, 1'b0, 1'b0);
    step();
    chk({rd_req_valid, fatal_valid, blocked_valid} == 3'b0, "R1 clean event dropped",
        {rd_req_valid, fatal_valid, blocked_valid}, 0);
  endtask

  task automatic t_soft();
    rd_req_ready = 1'b0;
    push(5, 1'b1, 1'b0);
    step();
    chk(rd_req_valid == 1'b1, "R3 re-read request raised", rd_req_valid, 1);
    chk(rd_req_line == 5, "R3 re-read line", rd_req_line, 5);
    step();
    step();
    chk(rd_req_valid && rd_req_line == 5, "R3 request held without ready", rd_req_line, 5);
    rd_req_ready = 1'b1;
    step();
    rd_req_ready = 1'b0;
    chk(rd_req_valid == 1'b0, "R3 request drops after ready", rd_req_valid, 0);
    respond(1'b0, 1'b0);
    chk(mv_req_valid == 1'b0, "R4 no relocation after clean re-read", mv_req_valid, 0);
    step();
    chk(mv_req_valid == 1'b0 && line_dis[5] == 1'b0, "R4 line 5 stays in service",
        line_dis[5], 0);
  endtask

  task automatic t_retire();
    rd_req_ready = 1'b1;
    push(9, 1'b1, 1'b0);
    step();
    chk(rd_req_valid && rd_req_line == 9, "R3 re-read line 9", rd_req_line, 9);
    step();
    rd_req_ready = 1'b0;
    respond(1'b1, 1'b0);
    chk(mv_req_valid == 1'b1, "R5 relocate request raised", mv_req_valid, 1);
    chk(mv_req_line == 9, "R5 relocate line", mv_req_line, 9);
    step();
    chk(mv_req_valid && mv_req_line == 9, "R5 relocate held without ready", mv_req_line, 9);
    mv_req_ready = 1'b1;
    step();
    mv_req_ready = 1'b0;
    chk(line_dis[9] == 1'b0, "R5 line not disabled before done", line_dis[9], 0);
    step();
    chk(line_dis[9] == 1'b0, "R5 line not disabled while waiting", line_dis[9], 0);
    mv_done = 1'b1;
    step();
    mv_done = 1'b0;
    chk(line_dis[9] == 1'b1, "R5 line disabled after done", line_dis[9], 1);
    chk(line_dis == (64'd1 << 9), "R6 only line 9 disabled", longint'(line_dis), longint'(64'd1 << 9));
  endtask

  task automatic t_blocked();
    push(9, 1'b1, 1'b0);
    step();
    chk(blocked_valid && blocked_line == 9, "R9 blocked on disabled line", blocked_line, 9);
    chk(rd_req_valid == 1'b0, "R9 no re-read for disabled line", rd_req_valid, 0);
    push(9, 1'b0, 1'b1);
    step();
    chk(blocked_valid == 1'b1, "R9 blocked wins over uncorrectable", blocked_valid, 1);
    chk(fatal_valid == 1'b0, "R9 no fatal for disabled line", fatal_valid, 0);
    chk(line_dis[9] == 1'b1, "R6 bit still set", line_dis[9], 1);
  endtask

  task automatic t_fatal_evt();
    push(12, 1'b0, 1'b1);
    step();
    chk(fatal_valid && fatal_line == 12, "R7 fatal for uncorrectable event", fatal_line, 12);
    chk(rd_req_valid == 1'b0, "R7 no re-read for uncorrectable", rd_req_valid, 0);
    step();
    chk(fatal_valid == 1'b0, "R7 fatal is one cycle", fatal_valid, 0);
  endtask

  task automatic t_fatal_rd();
    rd_req_ready = 1'b1;
    push(20, 1'b1, 1'b0);
    step();
    chk(rd_req_valid && rd_req_line == 20, "R3 re-read line 20", rd_req_line, 20);
    step();
    rd_req_ready = 1'b0;
    respond(1'b1, 1'b1);
    chk(fatal_valid && fatal_line == 20, "R8 fatal on re-read", fatal_line, 20);
    chk(mv_req_valid == 1'b0, "R8 no relocation", mv_req_valid, 0);
    step();
    chk(mv_req_valid == 1'b0 && line_dis[20] == 1'b0, "R8 line stays enabled", line_dis[20], 0);
  endtask

  task automatic t_order_ovf();
    rd_req_ready = 1'b0;
    for (int i = 0; i < 5; i++) push(30 + i, 1'b1, 1'b0);
    chk(evt_ready == 1'b0, "R1 evt_ready low when queue full", evt_ready, 0);
    chk(ovf == 1'b0, "R2 no overflow yet", ovf, 0);
    evt_valid = 1'b1;
    evt_line  = IDX_W'(35);
    evt_corr  = 1'b1;
    step();
    evt_valid = 1'b0;
    evt_corr  = 1'b0;
    chk(ovf == 1'b1, "R2 overflow flagged", ovf, 1);
    for (int i = 0; i < 5; i++) begin
      chk(rd_req_valid && rd_req_line == IDX_W'(30 + i), "R10 arrival order",
          rd_req_line, 30 + i);
      rd_req_ready = 1'b1;
      step();
      rd_req_ready = 1'b0;
      respond(1'b0, 1'b0);
      step();
    end
    chk(rd_req_valid == 1'b0, "R1 dropped event not processed", rd_req_valid, 0);
    chk(ovf == 1'b1, "R2 overflow sticky", ovf, 1);
    chk(evt_ready == 1'b1, "R1 evt_ready back high", evt_ready, 1);
  endtask

  task automatic t_reset_clears();
    do_reset();
    chk(line_dis == '0, "R6 reset clears disable map", longint'(line_dis), 0);
    chk(ovf == 1'b0, "R2 reset clears overflow", ovf, 0);
  endtask

  initial begin
    evt_valid = 0; evt_line = '0; evt_corr = 0; evt_uncorr = 0;
    rd_req_ready = 0; rd_rsp_valid = 0; rd_rsp_corr = 0; rd_rsp_uncorr = 0;
    mv_req_ready = 0; mv_done = 0;
    @(negedge clk);
    do_reset();
    t_reset();
    t_clean_evt();
    t_soft();
    t_retire();
    t_blocked();
    t_fatal_evt();
    t_fatal_rd();
    t_order_ovf();
    t_reset_clears();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule